// File: doc/BRIEF.md
# Eight-Way Addressable Bit Latch with Demultiplexer

This block keeps a bank of eight single-bit storage registers that are driven straight onto an 8-bit output bus. A 3-bit select value picks one bit. A single data input supplies the value that is written into that bit. Two active-low controls choose the mode for each cycle:

- **Write** (`clear_n` high, `enable_n` low): updates only the selected bit.
- **Hold** (`clear_n` high, `enable_n` high): freezes the whole bank.
- **Demux** (`clear_n` low, `enable_n` low): turns the bank into a one-hot 1-to-8 demultiplexer.
- **Clear** (`clear_n` low, `enable_n` high): zeroes every bit.

The model is clocked. The controls, select and data are sampled on each rising clock edge, and the registered bus shows the result after that edge. The block has no separate reset pin. Driving `clear_n` low for one cycle brings the bank to a known all-zero state. The select value should be changed only while `enable_n` is high.

Top module: `addr_latch_demux`

## Requirements
- R1: When `clear_n`=1 and `enable_n`=0 at a rising edge, output bit `sel` takes the value of `din`, and the other seven bits keep their values.
- R2: When `clear_n`=1 and `enable_n`=1 at a rising edge, all eight output bits keep their values, whatever `sel` and `din` are.
- R3: When `clear_n`=0 and `enable_n`=0 at a rising edge, output bit `sel` takes `din` and the other seven bits become 0. At most one bit is then high.
- R4: When `clear_n`=0 and `enable_n`=1 at a rising edge, all eight output bits become 0, whatever `sel` and `din` are.
- R5: `sel` is an unsigned binary index, with `sel[2]` as the most significant bit. Value i addresses output bit `q_out[i]`, so 0 maps to bit 0 and 7 maps to bit 7.
- R6: The output bus is registered. A change on the inputs appears on `q_out` only after the next rising edge of `clk`, and not before it.
- R7: After a demux or clear cycle, hold cycles keep exactly the pattern that the last demux or clear cycle produced.
- R8: Changing `sel` on every cycle while `enable_n`=1 and `clear_n`=1 leaves every stored bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge sampling clock |
| clear_n | input | 1 | Active-low clear control |
| enable_n | input | 1 | Active-low write enable |
| sel | input | 3 | Binary index of the addressed bit |
| din | input | 1 | Data bit for the addressed position |
| q_out | output | 8 | Registered storage bits; bit i belongs to index i |

## Verification
In demux mode, two actions happen in the same cycle: the addressed bit is written and every other bit is forced low.

The bench provokes this by first building a multi-bit pattern with write cycles and then switching to demux with a different select value. The result is judged correct only if the addressed bit equals the data and every previously set bit has dropped.

The same collision is checked with a data value of zero, which must leave the whole bus zero. It is also checked at every select value.

// File: rtl/adl_pkg.sv
package adl_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } adl_mode_t;
endpackage

// File: rtl/adl_mode_dec.sv
module adl_mode_dec
  import adl_pkg::*;
(
  input  logic      clear_n,
  input  logic      enable_n,
  output adl_mode_t mode
);
  always_comb begin
    unique case ({clear_n, enable_n})
      2'b10:   mode = MODE_WRITE;
      2'b11:   mode = MODE_HOLD;
      2'b00:   mode = MODE_DEMUX;
      default: mode = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/adl_onehot.sv
module adl_onehot #(
  parameter int NUM_BITS = 8,
  localparam int SEL_W = $clog2(NUM_BITS)
) (
  input  logic [SEL_W-1:0]    sel,
  output logic [NUM_BITS-1:0] hit
);
  for (genvar i = 0; i < NUM_BITS; i++) begin : g_hit
    assign hit[i] = (sel == SEL_W'(i));
  end
endmodule

// File: rtl/adl_cell.sv
module adl_cell
  import adl_pkg::*;
(
  input  logic      clk,
  input  adl_mode_t mode,
  input  logic      hit,
  input  logic      din,
  output logic      q
);
  logic nxt;

  always_comb begin
    unique case (mode)
      MODE_WRITE: nxt = hit ? din : q;
      MODE_HOLD:  nxt = q;
      MODE_DEMUX: nxt = hit & din;
      default:    nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) q <= nxt;
endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
  import adl_pkg::*;
#(
  parameter int NUM_BITS = 8,
  localparam int SEL_W = $clog2(NUM_BITS)
) (
  input  logic                clk,
  input  logic                clear_n,
  input  logic                enable_n,
  input  logic [SEL_W-1:0]    sel,
  input  logic                din,
  output logic [NUM_BITS-1:0] q_out
);
  adl_mode_t           mode;
  logic [NUM_BITS-1:0] hit;

  adl_mode_dec u_mode (
    .clear_n (clear_n),
    .enable_n(enable_n),
    .mode    (mode)
  );

  adl_onehot #(.NUM_BITS(NUM_BITS)) u_dec (
    .sel(sel),
    .hit(hit)
  );

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
    adl_cell u_cell (
      .clk (clk),
      .mode(mode),
      .hit (hit[i]),
      .din (din),
      .q   (q_out[i])
    );
  end
endmodule

// File: rtl/adl_checker.sv
module adl_checker #(
  parameter int NUM_BITS = 8,
  localparam int SEL_W = $clog2(NUM_BITS)
) (
  input logic                clk,
  input logic                clear_n,
  input logic                enable_n,
  input logic [SEL_W-1:0]    sel,
  input logic                din,
  input logic [NUM_BITS-1:0] q_out
);
  // The bank is unknown until a clear has been sampled; two stages keep $past defined.
  logic seen_clear = 1'b0;
  logic armed      = 1'b0;
  always @(posedge clk) begin
    if (!clear_n) seen_clear <= 1'b1;
    armed <= seen_clear;
  end

  assert_write_R1: assert property (@(posedge clk) disable iff (!armed)
    ($past(clear_n) && !$past(enable_n)) |->
      (q_out[$past(sel)] == $past(din)) &&
      ((q_out & ~(NUM_BITS'(1) << $past(sel))) == ($past(q_out) & ~(NUM_BITS'(1) << $past(sel)))));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!armed)
    ($past(clear_n) && $past(enable_n)) |-> (q_out == $past(q_out)));

  assert_demux_R3: assert property (@(posedge clk) disable iff (!armed)
    (!$past(clear_n) && !$past(enable_n)) |->
      ($countones(q_out) <= 1) && (q_out == (NUM_BITS'($past(din)) << $past(sel))));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!armed)
    (!$past(clear_n) && $past(enable_n)) |-> (q_out == '0));
endmodule

bind addr_latch_demux adl_checker #(.NUM_BITS(NUM_BITS)) u_chk (
  .clk     (clk),
  .clear_n (clear_n),
  .enable_n(enable_n),
  .sel     (sel),
  .din     (din),
  .q_out   (q_out)
);

// File: tb/sim_addr_latch_demux.sv
`timescale 1ns/1ps
module sim_addr_latch_demux;
  localparam int NB = 8;

  logic          clk = 1'b0;
  logic          clear_n = 1'b0;
  logic          enable_n = 1'b1;
  logic [2:0]    sel = '0;
  logic          din = 1'b0;
  logic [NB-1:0] q_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addr_latch_demux #(.NUM_BITS(NB)) u0 (
    .clk(clk), .clear_n(clear_n), .enable_n(enable_n),
    .sel(sel), .din(din), .q_out(q_out)
  );

  // Vector: {clear_n, enable_n, sel[2:0], din, expected q_out[7:0]}
  localparam int NV = 15;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 1'b1, 3'd5, 1'b1, 8'h00},
    {1'b1, 1'b0, 3'd0, 1'b1, 8'h01},
    {1'b1, 1'b0, 3'd7, 1'b1, 8'h81},
    {1'b1, 1'b0, 3'd3, 1'b1, 8'h89},
    {1'b1, 1'b0, 3'd0, 1'b0, 8'h88},
    {1'b1, 1'b1, 3'd2, 1'b1, 8'h88},
    {1'b1, 1'b1, 3'd6, 1'b0, 8'h88},
    {1'b0, 1'b0, 3'd4, 1'b1, 8'h10},
    {1'b1, 1'b1, 3'd1, 1'b1, 8'h10},
    {1'b0, 1'b0, 3'd6, 1'b0, 8'h00},
    {1'b1, 1'b0, 3'd5, 1'b1, 8'h20},
    {1'b0, 1'b0, 3'd2, 1'b1, 8'h04},
    {1'b1, 1'b0, 3'd6, 1'b1, 8'h44},
    {1'b0, 1'b1, 3'd6, 1'b1, 8'h00},
    {1'b1, 1'b1, 3'd3, 1'b0, 8'h00}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 13:            return "R4 clear";
      1, 2, 3, 4, 10, 12: return "R1 write / R5 index";
      5:                return "R2 hold";
      6:                return "R8 select moves in hold";
      7, 9, 11:         return "R3 demux";
      default:          return "R7 hold after demux/clear";
    endcase
  endfunction

  task automatic check(input logic [NB-1:0] act, input logic [NB-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic e, input logic [2:0] s, input logic d);
    @(negedge clk);
    clear_n = c; enable_n = e; sel = s; din = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [NB-1:0] model;
    // Table walk: apply at negedge, judge one time unit after the next rising edge.
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][13], VEC[i][12], VEC[i][11:9], VEC[i][8]);
      @(posedge clk); #1;
      check(q_out, VEC[i][7:0], tag_of(i));
    end

    // R6: a new write is not visible before the edge, only after it.
    drive(1'b1, 1'b0, 3'd1, 1'b1);
    #1 check(q_out, 8'h00, "R6 before edge");
    @(posedge clk); #1;
    check(q_out, 8'h02, "R6 after edge");

    // R8: sweep select and data every cycle with enable high.
    drive(1'b1, 1'b0, 3'd6, 1'b1);
    @(posedge clk); #1;
    check(q_out, 8'h42, "R1 setup for R8");
    for (int s = 0; s < NB; s++) begin
      drive(1'b1, 1'b1, 3'(s), s[0]);
      @(posedge clk); #1;
      check(q_out, 8'h42, "R8 select sweep in hold");
    end

    // R3 / R5: demux at every index, each one starting from a full bank.
    for (int s = 0; s < NB; s++) begin
      drive(1'b0, 1'b1, 3'd0, 1'b0);
      for (int k = 0; k < NB; k++) drive(1'b1, 1'b0, 3'(k), 1'b1);
      drive(1'b0, 1'b0, 3'(s), 1'b1);
      @(posedge clk); #1;
      model = NB'(1) << s;
      check(q_out, model, "R3 demux index / R5");
      drive(1'b1, 1'b1, 3'(NB - 1 - s), 1'b0);
      @(posedge clk); #1;
      check(q_out, model, "R7 hold after demux");
    end

    // R4: clear from a full bank with data and select active.
    for (int k = 0; k < NB; k++) drive(1'b1, 1'b0, 3'(k), 1'b1);
    drive(1'b0, 1'b1, 3'd7, 1'b1);
    @(posedge clk); #1;
    check(q_out, 8'h00, "R4 clear from full");
    drive(1'b1, 1'b1, 3'd2, 1'b1);
    @(posedge clk); #1;
    check(q_out, 8'h00, "R7 hold after clear");

    finish_run();
  end
endmodule